// File: doc/BRIEF.md
# Contact Smart Card Session Sequencer

This block starts and stops a contact smart card session in a safe order. The host asks for card power with an active-low, edge-sensitive command. The block then powers the card and checks the card supply. After that it opens the card I/O for reception, starts the card clock and, later, releases the card reset. Removing the command reverses the order. A fault or a card removal during a session also reverses it, with no action needed from the host.

All delays come from a slow timebase tick, so the same logic serves full-length intervals and short ones. The card reset is also gated by a count of card-clock edges, which is supplied as a one-cycle pulse per edge. A single active-low interrupt reports card presence while no session runs. During a session it reports a fault, which stays latched until the host withdraws the command.

Top module: `card_session_seq`

## Requirements
- R1: Card presence is `det_hi | ~det_lo_n`. While `cmd_n` is high and card power is off, `irq_n` equals presence, and the fault inputs have no effect on any output.
- R2: Activation (`vcc_en` rising on the next clock) starts only when the block is idle, a card is present, and `cmd_n` has fallen since the previous clock. A `cmd_n` that stays low does not start a session.
- R3: A stabilization window of `STAB_TICKS` ticks follows reset, the release of `pd_req`, and the release of `vdd_fault` outside a session. A `cmd_n` edge inside that window is discarded, and the host must toggle `cmd_n` again afterwards.
- R4: On activation the outputs switch in this order. `vcc_en` rises first. `io_rx_en` follows about `T1_TICKS + T2_TICKS` ticks later. `cclk_en` follows about `T3_TICKS` ticks after that.
- R5: If `vcc_fault` is high when the `T1_TICKS` supply check ends, `vcc_en` drops, `io_rx_en` never rises and `irq_n` goes low.
- R6: `card_rst` equals `rst_req` only after `RST_HOLD` pulses of `cclk_edge` have been seen while `cclk_en` is high. Before that it is low, even if `rst_req` is high.
- R7: Deactivation switches the outputs in this order, with gaps of about `G_RST`, `G_CLK`, `G_IO` and `G_PWR` ticks: `card_rst` low, then `cclk_en` low, then `io_rx_en` low, then `vcc_en` low.
- R8: The host ends a session by raising `cmd_n`. This runs the R7 sequence and leaves `irq_n` high.
- R9: During a session, overcurrent, over-temperature, logic-supply fault, card-supply fault or card removal starts the R7 sequence. `irq_n` goes low on the next clock and stays low until `cmd_n` is high.
- R10: `pd_req` is ignored while `cmd_n` is low. With `cmd_n` high and the block idle, `pd_req` enters power-down, and in power-down `cmd_n` edges are discarded.
- R11: After a fault shutdown, no new session starts while `cmd_n` stays low. A high-then-low toggle of `cmd_n` starts one.
- R12: At all times `card_rst` implies `cclk_en`, `cclk_en` implies `io_rx_en`, and `io_rx_en` implies `vcc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| cclk_edge | input | 1 | One-cycle pulse per card clock edge |
| cmd_n | input | 1 | Host session command, active low, edge-sensitive |
| rst_req | input | 1 | Host request for the card reset line |
| pd_req | input | 1 | Host power-down request |
| vdd_fault | input | 1 | Logic supply below threshold |
| vcc_fault | input | 1 | Card supply not valid |
| ovc_fault | input | 1 | Card overcurrent |
| hot_fault | input | 1 | Over-temperature |
| det_hi | input | 1 | Presence switch, high means card present |
| det_lo_n | input | 1 | Presence switch, low means card present |
| vcc_en | output | 1 | Card power enable |
| cclk_en | output | 1 | Card clock gate enable |
| card_rst | output | 1 | Card reset line |
| io_rx_en | output | 1 | Card I/O reception enable |
| irq_n | output | 1 | Active-low presence/fault interrupt |

## Verification
A wrong sequencer state shows at the four card outputs at once. It either breaks the nesting of power, I/O, clock and reset within one clock, or it moves a step by whole tick periods, which the bench measures against the parameter values. A wrong fault latch appears on `irq_n` one clock after the fault or after `cmd_n` rises. A wrong clock-edge count shows as `card_rst` departing from `rst_req` on the exact edge where the bench's own count passes `RST_HOLD`.

// File: rtl/card_seq_pkg.sv
// Shared types for the card session sequencer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package card_seq_pkg;

    // Sequencer states: stabilization, idle, power-down, activation steps,
    // running session, and deactivation steps.
    typedef enum logic [3:0] {
        S_STAB,
        S_IDLE,
        S_PD,
        S_PWRUP,
        S_IOW,
        S_CLKW,
        S_RUN,
        S_DRST,
        S_DCLK,
        S_DIO,
        S_DPWR
    } seq_state_t;

    // Larger of two integers, used to size the shared interval counter.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
// Tick-driven down counter shared by all sequencer intervals.
// Loading N makes `expired` true after N ticks have passed.
// Assumes: load and tick are single-cycle strobes; load takes priority.
module seq_timer #(
    parameter int TW   = 8,
    parameter int INIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    // Reload on request, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= TW'(INIT);
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/card_clk_count.sv
// Counts card clock edges while the card clock runs and saturates at HOLD.
// `done` allows the card reset to follow the host request.
// Assumes: run drops whenever the card clock is gated off.
module card_clk_count #(
    parameter int HOLD = 42000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic edge_in,
    output logic done
);
    localparam int CW = $clog2(HOLD + 1);
    logic [CW-1:0] cnt;

    // Clear while the clock is stopped, count edges up to the hold limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (edge_in && cnt != CW'(HOLD))
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == CW'(HOLD));
endmodule

// File: rtl/card_host_front.sv
// Host-side conditioning: merges the two presence inputs, finds the
// falling edge of the session command and merges the hard fault flags.
// Assumes: all inputs are already synchronous to clk.
module card_host_front (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_n,
    input  logic det_hi,
    input  logic det_lo_n,
    input  logic vdd_fault,
    input  logic ovc_fault,
    input  logic hot_fault,
    output logic present,
    output logic cmd_fall,
    output logic hard_fault
);
    logic cmd_prev;

    // Remember the last command level; reset treats it as inactive (high).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_prev <= 1'b1;
        else
            cmd_prev <= cmd_n;
    end

    assign present    = det_hi | ~det_lo_n;
    assign cmd_fall   = cmd_prev & ~cmd_n;
    assign hard_fault = ovc_fault | hot_fault | vdd_fault | ~present;
endmodule

// File: rtl/card_session_seq.sv
// Card session sequencer top. Orders card power, I/O reception, card clock
// and card reset on activation and reverses them on deactivation.
// Drives an active-low interrupt that shows presence outside a session and
// a latched fault inside one.
// Assumes: the tick period sets all intervals; cclk_edge pulses once per
// card clock edge; inputs are synchronous.
module card_session_seq
    import card_seq_pkg::*;
#(
    parameter int STAB_TICKS = 15000,
    parameter int T1_TICKS   = 750,
    parameter int T2_TICKS   = 3,
    parameter int T3_TICKS   = 1,
    parameter int G_RST      = 1,
    parameter int G_CLK      = 12,
    parameter int G_IO       = 1,
    parameter int G_PWR      = 1,
    parameter int RST_HOLD   = 42000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cclk_edge,
    input  logic cmd_n,
    input  logic rst_req,
    input  logic pd_req,
    input  logic vdd_fault,
    input  logic vcc_fault,
    input  logic ovc_fault,
    input  logic hot_fault,
    input  logic det_hi,
    input  logic det_lo_n,
    output logic vcc_en,
    output logic cclk_en,
    output logic card_rst,
    output logic io_rx_en,
    output logic irq_n
);
    localparam int TMAX = imax(imax(imax(STAB_TICKS, T1_TICKS), imax(T2_TICKS, T3_TICKS)),
                               imax(imax(G_RST, G_CLK), imax(G_IO, G_PWR)));
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_t    st, nxt;
    logic          present, cmd_fall, hard_fault, fault_now, in_act;
    logic          expired, ld, hold_done;
    logic [TW-1:0] ldv;
    logic          vcc_q, io_q, clk_q, rst_ok_q, flag_q;
    logic          vcc_set, vcc_clr, io_set, io_clr, clk_set, clk_clr, rst_clr;
    logic          t1_fail, flag_set;

    card_host_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_n      (cmd_n),
        .det_hi     (det_hi),
        .det_lo_n   (det_lo_n),
        .vdd_fault  (vdd_fault),
        .ovc_fault  (ovc_fault),
        .hot_fault  (hot_fault),
        .present    (present),
        .cmd_fall   (cmd_fall),
        .hard_fault (hard_fault)
    );

    seq_timer #(.TW(TW), .INIT(STAB_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (ld),
        .load_val (ldv),
        .expired  (expired)
    );

    card_clk_count #(.HOLD(RST_HOLD)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (clk_q),
        .edge_in (cclk_edge),
        .done    (hold_done)
    );

    // The card supply is only judged after the T1 check point.
    assign fault_now = hard_fault | (vcc_fault & (st != S_PWRUP));
    assign in_act    = (st == S_PWRUP) || (st == S_IOW) || (st == S_CLKW) || (st == S_RUN);
    assign flag_set  = ~cmd_n & ((vcc_q & fault_now) | t1_fail);

    // Next state, interval reloads and output set/clear strobes.
    always_comb begin
        nxt = st; ld = 1'b0; ldv = '0;
        vcc_set = 1'b0; vcc_clr = 1'b0; io_set = 1'b0; io_clr = 1'b0;
        clk_set = 1'b0; clk_clr = 1'b0; rst_clr = 1'b0; t1_fail = 1'b0;
        if (in_act && (cmd_n || fault_now)) begin
            nxt = S_DRST; ld = 1'b1; ldv = TW'(G_RST);
        end else begin
            case (st)
                S_STAB: begin
                    if (vdd_fault) begin
                        ld = 1'b1; ldv = TW'(STAB_TICKS);
                    end else if (expired) nxt = S_IDLE;
                end
                S_IDLE: begin
                    if (vdd_fault) begin
                        nxt = S_STAB; ld = 1'b1; ldv = TW'(STAB_TICKS);
                    end else if (pd_req && cmd_n) nxt = S_PD;
                    else if (cmd_fall && present) begin
                        nxt = S_PWRUP; ld = 1'b1; ldv = TW'(T1_TICKS); vcc_set = 1'b1;
                    end
                end
                S_PD: begin
                    if (!pd_req) begin
                        nxt = S_STAB; ld = 1'b1; ldv = TW'(STAB_TICKS);
                    end
                end
                S_PWRUP: begin
                    if (expired && vcc_fault) begin
                        nxt = S_IDLE; vcc_clr = 1'b1; t1_fail = 1'b1;
                    end else if (expired) begin
                        nxt = S_IOW; ld = 1'b1; ldv = TW'(T2_TICKS);
                    end
                end
                S_IOW: begin
                    if (expired) begin
                        nxt = S_CLKW; ld = 1'b1; ldv = TW'(T3_TICKS); io_set = 1'b1;
                    end
                end
                S_CLKW: begin
                    if (expired) begin
                        nxt = S_RUN; clk_set = 1'b1;
                    end
                end
                S_RUN: nxt = S_RUN;
                S_DRST: begin
                    if (expired) begin
                        nxt = S_DCLK; ld = 1'b1; ldv = TW'(G_CLK); rst_clr = 1'b1;
                    end
                end
                S_DCLK: begin
                    if (expired) begin
                        nxt = S_DIO; ld = 1'b1; ldv = TW'(G_IO); clk_clr = 1'b1;
                    end
                end
                S_DIO: begin
                    if (expired) begin
                        nxt = S_DPWR; ld = 1'b1; ldv = TW'(G_PWR); io_clr = 1'b1;
                    end
                end
                S_DPWR: begin
                    if (expired) begin
                        nxt = S_IDLE; vcc_clr = 1'b1;
                    end
                end
                default: begin
                    nxt = S_STAB; ld = 1'b1; ldv = TW'(STAB_TICKS);
                end
            endcase
        end
    end

    // State register and registered card-side enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_STAB; vcc_q <= 1'b0; io_q <= 1'b0; clk_q <= 1'b0; rst_ok_q <= 1'b0;
        end else begin
            st <= nxt;
            if (vcc_set) vcc_q <= 1'b1; else if (vcc_clr) vcc_q <= 1'b0;
            if (io_set) io_q <= 1'b1; else if (io_clr) io_q <= 1'b0;
            if (clk_set) clk_q <= 1'b1; else if (clk_clr) clk_q <= 1'b0;
            if (clk_set) rst_ok_q <= 1'b1; else if (rst_clr) rst_ok_q <= 1'b0;
        end
    end

    // Session fault latch: set by an in-session fault, cleared by command high.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_n)
            flag_q <= 1'b0;
        else if (flag_set)
            flag_q <= 1'b1;
    end

    assign vcc_en   = vcc_q;
    assign io_rx_en = io_q;
    assign cclk_en  = clk_q;
    assign card_rst = rst_ok_q & hold_done & rst_req;
    assign irq_n    = flag_q ? 1'b0 : (vcc_q ? 1'b1 : present);
endmodule

// File: rtl/card_seq_checker.sv
// Temporal checks on the sequencer ports, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module card_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_n,
    input logic rst_req,
    input logic ovc_fault,
    input logic hot_fault,
    input logic det_hi,
    input logic det_lo_n,
    input logic vcc_en,
    input logic cclk_en,
    input logic card_rst,
    input logic io_rx_en,
    input logic irq_n
);
    AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> cclk_en); // R12
    AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_en |-> io_rx_en); // R12
    AST_IO_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        io_rx_en |-> vcc_en); // R12
    AST_RST_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> rst_req); // R6
    AST_START_ON_LOW_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en) |-> !$past(cmd_n)); // R2
    AST_IRQ_PRESENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n && $past(cmd_n) && !vcc_en) |-> (irq_n == (det_hi || !det_lo_n))); // R1
    AST_FAULT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_en && !cmd_n && (ovc_fault || hot_fault)) |=> !irq_n); // R9
endmodule

bind card_session_seq card_seq_checker u_chk (.*);

// File: tb/card_session_seq_test.sv
module card_session_seq_test;
    localparam int TP = 3;
    localparam int STAB = 8, T1 = 5, T2 = 2, T3 = 1;
    localparam int GR = 1, GC = 5, GI = 1, GP = 1, HOLD = 20;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cclk_edge = 1'b0;
    logic cmd_n = 1'b1, rst_req = 1'b0, pd_req = 1'b0;
    logic vdd_fault = 1'b0, vcc_fault = 1'b0, ovc_fault = 1'b0, hot_fault = 1'b0;
    logic det_hi = 1'b1, det_lo_n = 1'b1;
    logic vcc_en, cclk_en, card_rst, io_rx_en, irq_n;
    int   total = 0, fails = 0;

    card_session_seq #(
        .STAB_TICKS(STAB), .T1_TICKS(T1), .T2_TICKS(T2), .T3_TICKS(T3),
        .G_RST(GR), .G_CLK(GC), .G_IO(GI), .G_PWR(GP), .RST_HOLD(HOLD)
    ) uut (.*);

    always #5 clk = ~clk;

    initial begin : tick_gen
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % TP;
            tick = (ph == 0);
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("[TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end

    function automatic logic sig(input int id);
        case (id)
            0: return vcc_en;
            1: return io_rx_en;
            2: return cclk_en;
            3: return card_rst;
            default: return irq_n;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_sig(input int id, input logic lvl, input int maxc, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sig(id) !== lvl && n < maxc);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R2, R4: falling command edge and the activation order with its spacing.
    task automatic activate();
        int n;
        cmd_n = 1'b0;
        wait_sig(0, 1'b1, 10, n);
        chk_rng("R2 cmd edge to power", n, 1, 2);
        wait_sig(1, 1'b1, 200, n);
        chk_rng("R4 power to io", n, TP*(T1+T2) - 2*TP, TP*(T1+T2) + 2*TP);
        wait_sig(2, 1'b1, 200, n);
        chk_rng("R4 io to clock", n, 1, TP*T3 + TP + 1);
        chk("R4 irq high in session", irq_n, 1);
    endtask

    initial begin : main
        int n;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        // Reset state.
        chk("R1 reset outputs", {vcc_en, io_rx_en, cclk_en, card_rst}, 0);
        chk("R1 reset irq shows card", irq_n, 1);

        // R3: a command edge inside the start-up window is lost.
        cmd_n = 1'b0;
        idle(40);
        chk("R3 edge in stabilization ignored", vcc_en, 0);
        cmd_n = 1'b1;
        idle(2);

        // R1: presence merge and faults ignored outside a session.
        det_hi = 1'b0; idle(1);
        chk("R1 no card irq low", irq_n, 0);
        det_lo_n = 1'b0; idle(1);
        chk("R1 low-side switch presence", irq_n, 1);
        det_lo_n = 1'b1; det_hi = 1'b1;
        ovc_fault = 1'b1; hot_fault = 1'b1; vcc_fault = 1'b1; idle(5);
        chk("R1 faults ignored outside", {irq_n, vcc_en}, 2);
        ovc_fault = 1'b0; hot_fault = 1'b0; vcc_fault = 1'b0; idle(2);

        // R2: no card means no session; a held-low command does not start one.
        det_hi = 1'b0;
        cmd_n = 1'b0; idle(30);
        chk("R2 no card no power", {vcc_en, irq_n}, 0);
        det_hi = 1'b1; idle(10);
        chk("R2 level without edge", vcc_en, 0);
        cmd_n = 1'b1; idle(2);

        // R4, R6: activation, then reset gating by card clock edges.
        rst_req = 1'b1;
        activate();
        begin : hold_check
            int edges = 0, mism = 0, seen = 0;
            for (int i = 0; i < 80; i++) begin
                if (card_rst !== (rst_req && edges >= HOLD)) mism++;
                if (card_rst === 1'b1) seen = 1;
                if (i == 60) rst_req = 1'b0;
                cclk_edge = (i % 2 == 0);
                if (cclk_en && cclk_edge) edges++;
                @(negedge clk);
            end
            cclk_edge = 1'b0;
            chk("R6 reset held off then follows", mism, 0);
            chk("R6 reset released", seen, 1);
        end
        rst_req = 1'b1; idle(1);
        chk("R6 reset follows request", card_rst, 1);

        // R10: power-down request ignored during a session.
        pd_req = 1'b1; idle(20);
        chk("R10 pd ignored in session", {vcc_en, cclk_en}, 3);
        pd_req = 1'b0; idle(1);

        // R7, R8: host deactivation order.
        cmd_n = 1'b1;
        wait_sig(3, 1'b0, 100, n);
        chk_rng("R7 cmd to reset low", n, 1, TP*GR + TP + 2);
        wait_sig(2, 1'b0, 100, n);
        chk_rng("R7 reset to clock low", n, TP*GC - TP, TP*GC + TP);
        wait_sig(1, 1'b0, 100, n);
        chk_rng("R7 clock to io low", n, 1, TP*GI + TP + 1);
        wait_sig(0, 1'b0, 100, n);
        chk_rng("R7 io to power low", n, 1, TP*GP + TP + 1);
        chk("R8 irq high after host stop", irq_n, 1);
        idle(4);

        // R9, R11: overcurrent during a session.
        activate();
        ovc_fault = 1'b1; idle(1);
        chk("R9 irq low after fault", irq_n, 0);
        idle(1); ovc_fault = 1'b0;
        wait_sig(0, 1'b0, 200, n);
        chk("R9 fault shuts power", vcc_en, 0);
        idle(40);
        chk("R11 no restart while low", {vcc_en, irq_n}, 0);
        cmd_n = 1'b1; idle(1);
        chk("R9 irq released by command high", irq_n, 1);
        idle(2);
        activate();

        // R9: card removal during a session.
        det_hi = 1'b0; idle(1);
        chk("R9 irq low on removal", irq_n, 0);
        wait_sig(0, 1'b0, 200, n);
        chk("R9 removal shuts power", vcc_en, 0);
        cmd_n = 1'b1; idle(2);
        det_hi = 1'b1; idle(2);

        // R5: card supply invalid at the end of the check interval.
        vcc_fault = 1'b1;
        cmd_n = 1'b0;
        wait_sig(0, 1'b1, 10, n);
        begin : t1_check
            int io_seen = 0, len = 0;
            while (vcc_en === 1'b1 && len < 100) begin
                @(negedge clk);
                len++;
                if (io_rx_en === 1'b1) io_seen = 1;
            end
            chk_rng("R5 power dropped after check", len, TP*T1 - TP, TP*T1 + TP);
            chk("R5 io never enabled", io_seen, 0);
            chk("R5 irq low", irq_n, 0);
        end
        vcc_fault = 1'b0;
        cmd_n = 1'b1; idle(2);

        // R10, R3: power-down, then restabilization.
        pd_req = 1'b1; idle(5);
        cmd_n = 1'b0; idle(10);
        chk("R10 edge in power-down ignored", vcc_en, 0);
        cmd_n = 1'b1; pd_req = 1'b0; idle(3);
        cmd_n = 1'b0; idle(40);
        chk("R3 edge after pd exit ignored", vcc_en, 0);
        cmd_n = 1'b1; idle(2);
        cmd_n = 1'b0;
        wait_sig(0, 1'b1, 10, n);
        chk("R3 toggle after window starts", vcc_en, 1);
        cmd_n = 1'b1;
        wait_sig(0, 1'b0, 200, n);

        // R3: logic supply dip outside a session restarts the window.
        vdd_fault = 1'b1; idle(5);
        vdd_fault = 1'b0; idle(3);
        cmd_n = 1'b0; idle(40);
        chk("R3 edge after supply dip ignored", vcc_en, 0);
        cmd_n = 1'b1; idle(4);

        $display("[TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end
endmodule